// File: doc/BRIEF.md
# Serial Flash Write-Protection Gate

This block sits behind the instruction decoder of a serial NOR flash slave and decides, for every decoded opcode, whether the device acts on it. It combines several protection layers in one place: a supply-good hold that keeps the device inert, a power-up window in which every write-class instruction is refused, a write enable latch that must be armed before each program, erase or status write and that drops once the array engine finishes, status-register locking through a protect bit plus the write-protect pin, a region-protection flag supplied by the address decode, a busy lockout, and a deep power-down mode that wakes only on its release instruction.

Each cycle with `cmd_valid` high presents one opcode. One clock edge later the block raises either `accept` or `reject` for exactly one cycle. The write enable latch and the power-down state are visible as outputs so the surrounding status logic can report them. The inhibit window length is the parameter `PUW_CYCLES`, counted in clock edges after the supply becomes good.

Top module: `wp_gate`

## Requirements
- R1: While `pwr_good` is low, a strobe produces neither `accept` nor `reject`, and `wel` and `pd_active` read 0 while `inhibit_active` reads 1.
- R2: For the first `PUW_CYCLES` clock edges after `pwr_good` goes high (with `rst` low), `inhibit_active` is 1 and the write-class opcodes 06h, 02h, 20h, D8h, C7h, 42h and 01h are rejected; other opcodes are judged normally; `inhibit_active` is 0 from edge `PUW_CYCLES` on.
- R3: Every strobe with power good yields exactly one of `accept` or `reject`, high for one cycle, after the edge that samples the strobe; an accepted 06h (write enable) sets `wel` and `wel` is 0 after reset.
- R4: 02h, 20h, D8h, C7h (program/erase), 42h (security register write) and 01h (status write) are accepted only when `wel` is 1; otherwise they are rejected and `wel` stays as it was.
- R5: A pulse on `op_done` clears `wel` at the next edge.
- R6: 01h is rejected when `srp` is 1 and `wp_n` is 0; with `wp_n` 1 or `srp` 0 it follows R4.
- R7: 02h, 20h, D8h and C7h are rejected when `prot_hit` is 1, and `wel` stays unchanged.
- R8: An accepted 04h (write disable) clears `wel`.
- R9: While `busy` is 1, only 05h (status read) is accepted; everything else is rejected.
- R10: An accepted B9h sets `pd_active`; while `pd_active` is 1 only ABh is accepted, and it clears `pd_active`; ABh outside power-down is accepted with no effect.
- R11: 03h (read) and 05h are accepted when not busy and not powered down; any opcode not named in these requirements is rejected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pwr_good | input | 1 | Supply above write-inhibit threshold |
| cmd_valid | input | 1 | Opcode strobe, one cycle per instruction |
| cmd_op | input | 8 | Decoded instruction opcode |
| wp_n | input | 1 | Write-protect pin level, active low |
| srp | input | 1 | Status-register protect bit |
| prot_hit | input | 1 | Target of the program/erase lies in a protected region |
| busy | input | 1 | Array engine busy |
| op_done | input | 1 | Array engine finished a program, erase or status write |
| accept | output | 1 | One-cycle pulse: instruction accepted |
| reject | output | 1 | One-cycle pulse: instruction ignored |
| wel | output | 1 | Write enable latch |
| pd_active | output | 1 | Deep power-down state |
| inhibit_active | output | 1 | Power-up write-inhibit window running |

## Verification
The assertions assume that `cmd_valid` is a single-cycle strobe per instruction, that `prot_hit`, `srp` and `wp_n` are settled in the strobe cycle, and that `op_done` arrives only while `busy` is high, so a write enable cannot land in the same cycle as a completion. The bench drives every input at the falling edge, holds the strobe for exactly one cycle and raises `op_done` only together with `busy`, so the stimulus stays inside those assumptions while still walking each gating layer and the exact edge on which the inhibit window closes.

// File: rtl/wp_gate_pkg.sv
package wp_gate_pkg;

    localparam int OP_W = 8;

    localparam logic [OP_W-1:0] OP_WREN   = 8'h06;
    localparam logic [OP_W-1:0] OP_WRDI   = 8'h04;
    localparam logic [OP_W-1:0] OP_PP     = 8'h02;
    localparam logic [OP_W-1:0] OP_SE     = 8'h20;
    localparam logic [OP_W-1:0] OP_BE     = 8'hD8;
    localparam logic [OP_W-1:0] OP_CE     = 8'hC7;
    localparam logic [OP_W-1:0] OP_SECWR  = 8'h42;
    localparam logic [OP_W-1:0] OP_WRSR   = 8'h01;
    localparam logic [OP_W-1:0] OP_PDN    = 8'hB9;
    localparam logic [OP_W-1:0] OP_RPD    = 8'hAB;
    localparam logic [OP_W-1:0] OP_RDSR   = 8'h05;
    localparam logic [OP_W-1:0] OP_READ   = 8'h03;

    typedef enum logic [3:0] {
        CLS_ARM,
        CLS_DISARM,
        CLS_MODIFY,
        CLS_SECWR,
        CLS_STWR,
        CLS_SLEEP,
        CLS_WAKE,
        CLS_STRD,
        CLS_READ,
        CLS_OTHER
    } op_class_e;

    typedef struct packed {
        logic take;
        logic set_wel;
        logic clr_wel;
        logic set_pd;
        logic clr_pd;
    } verdict_t;

    function automatic op_class_e classify(input logic [OP_W-1:0] op);
        op_class_e c;
        case (op)
            OP_WREN:                    c = CLS_ARM;
            OP_WRDI:                    c = CLS_DISARM;
            OP_PP, OP_SE, OP_BE, OP_CE: c = CLS_MODIFY;
            OP_SECWR:                   c = CLS_SECWR;
            OP_WRSR:                    c = CLS_STWR;
            OP_PDN:                     c = CLS_SLEEP;
            OP_RPD:                     c = CLS_WAKE;
            OP_RDSR:                    c = CLS_STRD;
            OP_READ:                    c = CLS_READ;
            default:                    c = CLS_OTHER;
        endcase
        return c;
    endfunction

    function automatic logic is_write_class(input op_class_e c);
        return (c == CLS_ARM) || (c == CLS_MODIFY) ||
               (c == CLS_SECWR) || (c == CLS_STWR);
    endfunction

endpackage

// File: rtl/wp_inhibit_timer.sv
module wp_inhibit_timer #(
    parameter int PUW_CYCLES = 64
) (
    input  logic clk,
    input  logic rst,
    input  logic pwr_good,
    output logic inhibit
);
    localparam int CNT_W = $clog2(PUW_CYCLES + 1);

    logic [CNT_W-1:0] remain;

    always_ff @(posedge clk) begin
        if (rst || !pwr_good) begin
            remain <= CNT_W'(PUW_CYCLES);
        end else if (remain != '0) begin
            remain <= remain - CNT_W'(1);
        end
    end

    assign inhibit = (remain != '0);

endmodule

// File: rtl/wp_decide.sv
module wp_decide
    import wp_gate_pkg::*;
(
    input  op_class_e cls,
    input  logic      wel,
    input  logic      pd,
    input  logic      busy,
    input  logic      inhibit,
    input  logic      srp,
    input  logic      wp_n,
    input  logic      prot_hit,
    output verdict_t  verdict
);
    logic sr_locked;

    assign sr_locked = srp && !wp_n;

    always_comb begin
        verdict = '0;
        if (pd) begin
            if (cls == CLS_WAKE) begin
                verdict.take   = 1'b1;
                verdict.clr_pd = 1'b1;
            end
        end else if (busy) begin
            verdict.take = (cls == CLS_STRD);
        end else if (inhibit && is_write_class(cls)) begin
            verdict.take = 1'b0;
        end else begin
            case (cls)
                CLS_ARM: begin
                    verdict.take    = 1'b1;
                    verdict.set_wel = 1'b1;
                end
                CLS_DISARM: begin
                    verdict.take    = 1'b1;
                    verdict.clr_wel = 1'b1;
                end
                CLS_MODIFY: verdict.take = wel && !prot_hit;
                CLS_SECWR:  verdict.take = wel;
                CLS_STWR:   verdict.take = wel && !sr_locked;
                CLS_SLEEP: begin
                    verdict.take   = 1'b1;
                    verdict.set_pd = 1'b1;
                end
                CLS_WAKE, CLS_STRD, CLS_READ: verdict.take = 1'b1;
                default:    verdict.take = 1'b0;
            endcase
        end
    end

endmodule

// File: rtl/wp_state_regs.sv
module wp_state_regs
    import wp_gate_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     pwr_good,
    input  logic     strobe,
    input  verdict_t verdict,
    input  logic     op_done,
    output logic     accept,
    output logic     reject,
    output logic     wel,
    output logic     pd
);
    logic fire;

    assign fire = strobe && verdict.take;

    always_ff @(posedge clk) begin
        if (rst || !pwr_good) begin
            accept <= 1'b0;
            reject <= 1'b0;
            wel    <= 1'b0;
            pd     <= 1'b0;
        end else begin
            accept <= fire;
            reject <= strobe && !verdict.take;
            if (fire && verdict.set_wel) wel <= 1'b1;
            if (fire && verdict.clr_wel) wel <= 1'b0;
            if (op_done)                 wel <= 1'b0;
            if (fire && verdict.set_pd)  pd  <= 1'b1;
            if (fire && verdict.clr_pd)  pd  <= 1'b0;
        end
    end

endmodule

// File: rtl/wp_gate.sv
module wp_gate
    import wp_gate_pkg::*;
#(
    parameter int PUW_CYCLES = 64
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            pwr_good,
    input  logic            cmd_valid,
    input  logic [OP_W-1:0] cmd_op,
    input  logic            wp_n,
    input  logic            srp,
    input  logic            prot_hit,
    input  logic            busy,
    input  logic            op_done,
    output logic            accept,
    output logic            reject,
    output logic            wel,
    output logic            pd_active,
    output logic            inhibit_active
);
    op_class_e cls;
    verdict_t  verdict;

    assign cls = classify(cmd_op);

    wp_inhibit_timer #(
        .PUW_CYCLES(PUW_CYCLES)
    ) u_timer (
        .clk     (clk),
        .rst     (rst),
        .pwr_good(pwr_good),
        .inhibit (inhibit_active)
    );

    wp_decide u_decide (
        .cls     (cls),
        .wel     (wel),
        .pd      (pd_active),
        .busy    (busy),
        .inhibit (inhibit_active),
        .srp     (srp),
        .wp_n    (wp_n),
        .prot_hit(prot_hit),
        .verdict (verdict)
    );

    wp_state_regs u_state (
        .clk     (clk),
        .rst     (rst),
        .pwr_good(pwr_good),
        .strobe  (cmd_valid),
        .verdict (verdict),
        .op_done (op_done),
        .accept  (accept),
        .reject  (reject),
        .wel     (wel),
        .pd      (pd_active)
    );

endmodule

// File: rtl/wp_gate_checker.sv
module wp_gate_checker
    import wp_gate_pkg::*;
(
    input logic            clk,
    input logic            rst,
    input logic            pwr_good,
    input logic            cmd_valid,
    input logic [OP_W-1:0] cmd_op,
    input logic            wp_n,
    input logic            srp,
    input logic            busy,
    input logic            op_done,
    input logic            accept,
    input logic            reject,
    input logic            wel,
    input logic            pd_active,
    input logic            inhibit_active
);
    assert_dead_supply_R1: assert property (@(posedge clk) disable iff (rst)
        !pwr_good |=> (!accept && !reject && !wel && !pd_active));

    assert_window_wren_R2: assert property (@(posedge clk) disable iff (rst)
        (pwr_good && inhibit_active && cmd_valid && cmd_op == OP_WREN) |=> !accept);

    assert_one_verdict_R3: assert property (@(posedge clk) disable iff (rst)
        !(accept && reject));

    assert_verdict_follows_strobe_R3: assert property (@(posedge clk) disable iff (rst)
        (accept || reject) |-> $past(cmd_valid && pwr_good));

    assert_done_clears_R5: assert property (@(posedge clk) disable iff (rst)
        op_done |=> !wel);

    assert_sr_lock_R6: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && cmd_op == OP_WRSR && srp && !wp_n) |=> !accept);

    assert_busy_lockout_R9: assert property (@(posedge clk) disable iff (rst)
        (busy && cmd_valid && cmd_op != OP_RDSR) |=> !accept);

    assert_sleep_gate_R10: assert property (@(posedge clk) disable iff (rst)
        (pd_active && cmd_valid && cmd_op != OP_RPD) |=> (!accept && pd_active));

endmodule

bind wp_gate wp_gate_checker u_wp_gate_checker (
    .clk           (clk),
    .rst           (rst),
    .pwr_good      (pwr_good),
    .cmd_valid     (cmd_valid),
    .cmd_op        (cmd_op),
    .wp_n          (wp_n),
    .srp           (srp),
    .busy          (busy),
    .op_done       (op_done),
    .accept        (accept),
    .reject        (reject),
    .wel           (wel),
    .pd_active     (pd_active),
    .inhibit_active(inhibit_active)
);

// File: tb/test_wp_gate.sv
`timescale 1ns/1ps
module test_wp_gate;

    localparam int PUW = 12;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       pwr_good = 1'b0;
    logic       cmd_valid = 1'b0;
    logic [7:0] cmd_op = 8'h00;
    logic       wp_n = 1'b1;
    logic       srp = 1'b0;
    logic       prot_hit = 1'b0;
    logic       busy = 1'b0;
    logic       op_done = 1'b0;
    logic       accept, reject, wel, pd_active, inhibit_active;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    wp_gate #(.PUW_CYCLES(PUW)) i_wp_gate (
        .clk(clk), .rst(rst), .pwr_good(pwr_good), .cmd_valid(cmd_valid),
        .cmd_op(cmd_op), .wp_n(wp_n), .srp(srp), .prot_hit(prot_hit),
        .busy(busy), .op_done(op_done), .accept(accept), .reject(reject),
        .wel(wel), .pd_active(pd_active), .inhibit_active(inhibit_active)
    );

    typedef struct packed {
        logic [7:0] op;
        logic       v;
        logic       wpn;
        logic       sp;
        logic       prot;
        logic       bsy;
        logic       done;
        logic       eacc;
        logic       erej;
        logic       ewel;
        logic       epd;
        logic [7:0] req;
    } vec_t;

    localparam int NV = 30;
    localparam vec_t VECS [NV] = '{
        //     op   v    wpn  srp  prot busy done acc  rej  wel  pd   req
        '{8'h04,1'b1,1'b1,1'b0,1'b0,1'b0,1'b0,1'b1,1'b0,1'b0,1'b0,8'd8},  // R8
        '{8'h02,1'b1,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,1'b0,1'b0,8'd4},  // R4
        '{8'h06,1'b1,1'b1,1'b0,1'b0,1'b0,1'b0,1'b1,1'b0,1'b1,1'b0,8'd3},  // R3
        '{8'h02,1'b1,1'b1,1'b0,1'b1,1'b0,1'b0,1'b0,1'b1,1'b1,1'b0,8'd7},  // R7
        '{8'h02,1'b1,1'b1,1'b0,1'b0,1'b0,1'b0,1'b1,1'b0,1'b1,1'b0,8'd4},  // R4
        '{8'h00,1'b0,1'b1,1'b0,1'b0,1'b1,1'b1,1'b0,1'b0,1'b0,1'b0,8'd5},  // R5
        '{8'h01,1'b1,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,1'b0,1'b0,8'd4},  // R4
        '{8'h06,1'b1,1'b1,1'b0,1'b0,1'b0,1'b0,1'b1,1'b0,1'b1,1'b0,8'd3},  // R3
        '{8'h01,1'b1,1'b0,1'b1,1'b0,1'b0,1'b0,1'b0,1'b1,1'b1,1'b0,8'd6},  // R6
        '{8'h01,1'b1,1'b1,1'b1,1'b0,1'b0,1'b0,1'b1,1'b0,1'b1,1'b0,8'd6},  // R6
        '{8'h00,1'b0,1'b1,1'b0,1'b0,1'b1,1'b1,1'b0,1'b0,1'b0,1'b0,8'd5},  // R5
        '{8'h06,1'b1,1'b1,1'b0,1'b0,1'b0,1'b0,1'b1,1'b0,1'b1,1'b0,8'd3},  // R3
        '{8'h04,1'b1,1'b1,1'b0,1'b0,1'b0,1'b0,1'b1,1'b0,1'b0,1'b0,8'd8},  // R8
        '{8'h06,1'b1,1'b1,1'b0,1'b0,1'b0,1'b0,1'b1,1'b0,1'b1,1'b0,8'd3},  // R3
        '{8'h20,1'b1,1'b1,1'b0,1'b0,1'b1,1'b0,1'b0,1'b1,1'b1,1'b0,8'd9},  // R9
        '{8'h05,1'b1,1'b1,1'b0,1'b0,1'b1,1'b0,1'b1,1'b0,1'b1,1'b0,8'd9},  // R9
        '{8'hD8,1'b1,1'b1,1'b0,1'b0,1'b0,1'b0,1'b1,1'b0,1'b1,1'b0,8'd4},  // R4
        '{8'h00,1'b0,1'b1,1'b0,1'b0,1'b1,1'b1,1'b0,1'b0,1'b0,1'b0,8'd5},  // R5
        '{8'hB9,1'b1,1'b1,1'b0,1'b0,1'b0,1'b0,1'b1,1'b0,1'b0,1'b1,8'd10}, // R10
        '{8'h06,1'b1,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,1'b0,1'b1,8'd10}, // R10
        '{8'h05,1'b1,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,1'b0,1'b1,8'd10}, // R10
        '{8'hAB,1'b1,1'b1,1'b0,1'b0,1'b0,1'b0,1'b1,1'b0,1'b0,1'b0,8'd10}, // R10
        '{8'hAB,1'b1,1'b1,1'b0,1'b0,1'b0,1'b0,1'b1,1'b0,1'b0,1'b0,8'd10}, // R10
        '{8'h06,1'b1,1'b1,1'b0,1'b0,1'b0,1'b0,1'b1,1'b0,1'b1,1'b0,8'd3},  // R3
        '{8'hC7,1'b1,1'b1,1'b0,1'b1,1'b0,1'b0,1'b0,1'b1,1'b1,1'b0,8'd7},  // R7
        '{8'hC7,1'b1,1'b1,1'b0,1'b0,1'b0,1'b0,1'b1,1'b0,1'b1,1'b0,8'd4},  // R4
        '{8'h77,1'b1,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,1'b1,1'b0,8'd11}, // R11
        '{8'h03,1'b1,1'b1,1'b0,1'b0,1'b0,1'b0,1'b1,1'b0,1'b1,1'b0,8'd11}, // R11
        '{8'h00,1'b0,1'b1,1'b0,1'b0,1'b1,1'b1,1'b0,1'b0,1'b0,1'b0,8'd5},  // R5
        '{8'h42,1'b1,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,1'b0,1'b0,8'd4}   // R4
    };

    task automatic check(input bit ok, input string req, input string what,
                         input int actual, input int expected);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, actual, expected);
        end
    endtask

    // Called at a falling edge: drive, let one rising edge pass, sample at the next fall.
    task automatic step(input logic v, input logic [7:0] op, input logic wpn,
                        input logic sp, input logic prot, input logic bsy,
                        input logic done);
        cmd_valid = v; cmd_op = op; wp_n = wpn; srp = sp;
        prot_hit = prot; busy = bsy; op_done = done;
        @(posedge clk);
        @(negedge clk);
        cmd_valid = 1'b0; op_done = 1'b0; busy = 1'b0; prot_hit = 1'b0;
    endtask

    task automatic cmd(input logic [7:0] op);
        step(1'b1, op, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            failures++;
            checks++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        // Reset state, R1 and R3
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(!accept && !reject, "R1", "pulses in reset", accept | reject, 0);
        check(wel == 1'b0, "R3", "wel after reset", wel, 0);
        check(pd_active == 1'b0, "R1", "pd in reset", pd_active, 0);
        check(inhibit_active == 1'b1, "R1", "inhibit in reset", inhibit_active, 1);
        rst = 1'b0;

        // R1: supply low, strobes ignored entirely
        cmd(8'h06);
        check(!accept && !reject, "R1", "strobe with supply low", accept | reject, 0);
        check(wel == 1'b0, "R1", "wel with supply low", wel, 0);

        // R2: inside the window, write class rejected, reads judged normally
        pwr_good = 1'b1;
        cmd(8'h06);
        check(reject && !accept, "R2", "WREN in window", accept, 0);
        cmd(8'h01);
        check(reject, "R2", "WRSR in window", reject, 1);
        cmd(8'h05);
        check(accept, "R2", "status read in window", accept, 1);
        check(inhibit_active == 1'b1, "R2", "window still open", inhibit_active, 1);

        // R2: exact closing edge of the window
        pwr_good = 1'b0;
        @(posedge clk);
        @(negedge clk);
        pwr_good = 1'b1;
        repeat (PUW - 1) @(posedge clk);
        @(negedge clk);
        check(inhibit_active == 1'b1, "R2", "inhibit one edge before end", inhibit_active, 1);
        @(posedge clk);
        @(negedge clk);
        check(inhibit_active == 1'b0, "R2", "inhibit at end", inhibit_active, 0);
        cmd(8'h06);
        check(accept && wel, "R2", "WREN after window", wel, 1);

        // Vector table
        for (int i = 0; i < NV; i++) begin
            string tag;
            tag = $sformatf("R%0d", VECS[i].req);
            step(VECS[i].v, VECS[i].op, VECS[i].wpn, VECS[i].sp,
                 VECS[i].prot, VECS[i].bsy, VECS[i].done);
            check(accept == VECS[i].eacc, tag, $sformatf("vec %0d accept", i),
                  accept, VECS[i].eacc);
            check(reject == VECS[i].erej, tag, $sformatf("vec %0d reject", i),
                  reject, VECS[i].erej);
            check(wel == VECS[i].ewel, tag, $sformatf("vec %0d wel", i),
                  wel, VECS[i].ewel);
            check(pd_active == VECS[i].epd, tag, $sformatf("vec %0d pd", i),
                  pd_active, VECS[i].epd);
        end

        // R3: pulse lasts a single cycle
        cmd(8'h03);
        @(posedge clk);
        @(negedge clk);
        check(!accept && !reject, "R3", "pulse width", accept, 0);

        // R1: supply loss clears the latch and power-down
        cmd(8'h06);
        cmd(8'hB9);
        check(wel && pd_active, "R10", "armed and asleep", pd_active, 1);
        pwr_good = 1'b0;
        @(posedge clk);
        @(negedge clk);
        check(wel == 1'b0, "R1", "wel after supply loss", wel, 0);
        check(pd_active == 1'b0, "R1", "pd after supply loss", pd_active, 0);

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule